// File: doc/BRIEF.md
# Lock-Step Bus Compare Monitor

This block sits between a master core, a checker core and the shared memory bus of a fail-silent processing node. Both cores run the same program cycle by cycle and receive the same fetched words. Only the master's bus request (strobe, write flag, address, write data) and its system output enables are passed on, through one register stage, to memory and the outside world. The checker's copy of these signals is used only for comparison.

On every cycle in which the master drives a bus request, the monitor compares each signal of the request pair by pair. A difference in any pair sets a sticky compare-fault flag on the closing clock edge. The flag does not say which core is wrong. Read data coming back over the shared path carries one even-parity bit per byte. A parity fault sets a second sticky flag, because a fault there reaches both cores alike and cannot show up as a disagreement between them. Either fault silences the node: from the edge that records the fault, every forwarded output is held at zero until synchronous reset.

Top module: `lockstep_monitor`

## Requirements
- R1: While `rst` is high at a clock edge, `cmp_err`, `par_err`, `silent` and all forwarded outputs (`bus_valid`, `bus_write`, `bus_addr`, `bus_wdata`, `sys_oe`) are 0 after that edge.
- R2: In a cycle with `m_valid`=1, if `c_valid`=0 or any of write flag, address, write data or output-enable bits differs between master and checker, `cmp_err` is 1 after the closing edge and stays 1 until reset.
- R3: In a cycle with `m_valid`=0, differences between master and checker signals have no effect: `cmp_err` keeps its value.
- R4: With no fault recorded and none detected in the current cycle, the forwarded outputs equal the master's inputs of that cycle one clock later. Checker inputs never appear on them.
- R5: In a cycle with `rd_valid`=1, if `rd_par[i]` differs from the XOR of `rd_data[8i+7:8i]` for any byte i (even parity), `par_err` is 1 after the closing edge and stays 1 until reset. With `rd_valid`=0, parity is ignored.
- R6: `silent` equals `cmp_err` OR `par_err`. Forwarded outputs are all 0 after the edge that records the first fault, and on every later edge, so the faulting request itself is not passed on.
- R7: A single-bit difference raises the same `cmp_err`, whether the master side or the checker side holds the altered value. No output identifies the faulty core.
- R8: A compare fault and a parity fault in the same cycle set both flags on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_valid | input | 1 | Master bus request strobe |
| m_write | input | 1 | Master write flag |
| m_addr | input | ADDR_W | Master address |
| m_wdata | input | DATA_W | Master write data |
| m_oe | input | OE_W | Master system output enables |
| c_valid | input | 1 | Checker bus request strobe |
| c_write | input | 1 | Checker write flag |
| c_addr | input | ADDR_W | Checker address |
| c_wdata | input | DATA_W | Checker write data |
| c_oe | input | OE_W | Checker system output enables |
| rd_valid | input | 1 | Shared read data valid |
| rd_data | input | DATA_W | Shared read data |
| rd_par | input | DATA_W/8 | Even parity bit per read-data byte |
| bus_valid | output | 1 | Forwarded request strobe |
| bus_write | output | 1 | Forwarded write flag |
| bus_addr | output | ADDR_W | Forwarded address |
| bus_wdata | output | DATA_W | Forwarded write data |
| sys_oe | output | OE_W | Forwarded system output enables |
| cmp_err | output | 1 | Sticky compare-fault flag |
| par_err | output | 1 | Sticky parity-fault flag |
| silent | output | 1 | Node silenced |

## Verification
A core disagreement and a parity fault on returning read data can fall in the same cycle, and the silencing must also act in that cycle on the request being forwarded. The bench provokes this directly, with a request whose checker address differs while the read data carries a wrong parity bit. It also provokes it by chance through random injection on both paths. It then expects both flags on one edge and a zero forwarded request. A reference model in the bench predicts every output on every cycle from the requirements alone.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int LANE_W = 8;

  typedef struct packed {
    logic valid;
    logic write;
  } ctrl_t;
endpackage

// File: rtl/lsm_lane_cmp.sv
module lsm_lane_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         diff
);
  assign diff = |(a ^ b);
endmodule

// File: rtl/lsm_pair_cmp.sv
module lsm_pair_cmp
  import lsm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int OE_W   = 4
) (
  input  ctrl_t              m_ctrl,
  input  ctrl_t              c_ctrl,
  input  logic [ADDR_W-1:0]  m_addr,
  input  logic [ADDR_W-1:0]  c_addr,
  input  logic [DATA_W-1:0]  m_wdata,
  input  logic [DATA_W-1:0]  c_wdata,
  input  logic [OE_W-1:0]    m_oe,
  input  logic [OE_W-1:0]    c_oe,
  output logic               mismatch
);
  localparam int LANES = DATA_W / LANE_W;

  logic             ctrl_diff;
  logic             addr_diff;
  logic             oe_diff;
  logic [LANES-1:0] lane_diff;

  lsm_lane_cmp #(.W(2)) u_ctrl (
    .a(m_ctrl), .b(c_ctrl), .diff(ctrl_diff)
  );

  lsm_lane_cmp #(.W(ADDR_W)) u_addr (
    .a(m_addr), .b(c_addr), .diff(addr_diff)
  );

  lsm_lane_cmp #(.W(OE_W)) u_oe (
    .a(m_oe), .b(c_oe), .diff(oe_diff)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lsm_lane_cmp #(.W(LANE_W)) u_data (
      .a(m_wdata[g*LANE_W +: LANE_W]),
      .b(c_wdata[g*LANE_W +: LANE_W]),
      .diff(lane_diff[g])
    );
  end

  // Comparison only in cycles with an active master request.
  assign mismatch = m_ctrl.valid & (ctrl_diff | addr_diff | oe_diff | (|lane_diff));
endmodule

// File: rtl/lsm_parity_chk.sv
module lsm_parity_chk
  import lsm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                     rd_valid,
  input  logic [DATA_W-1:0]        rd_data,
  input  logic [DATA_W/LANE_W-1:0] rd_par,
  output logic                     par_hit
);
  localparam int LANES = DATA_W / LANE_W;

  logic [LANES-1:0] lane_bad;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bad[g] = (^rd_data[g*LANE_W +: LANE_W]) ^ rd_par[g];
  end

  assign par_hit = rd_valid & (|lane_bad);
endmodule

// File: rtl/lsm_fault_latch.sv
module lsm_fault_latch (
  input  logic clk,
  input  logic rst,
  input  logic cmp_hit,
  input  logic par_hit,
  output logic block,
  output logic cmp_err,
  output logic par_err,
  output logic silent
);
  logic cmp_nxt;
  logic par_nxt;

  assign cmp_nxt = cmp_err | cmp_hit;
  assign par_nxt = par_err | par_hit;
  // Covers the detecting cycle as well as all later ones.
  assign block   = cmp_nxt | par_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_err <= 1'b0;
      par_err <= 1'b0;
      silent  <= 1'b0;
    end else begin
      cmp_err <= cmp_nxt;
      par_err <= par_nxt;
      silent  <= block;
    end
  end
endmodule

// File: rtl/lsm_out_gate.sv
module lsm_out_gate
  import lsm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int OE_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              block,
  input  ctrl_t             m_ctrl,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic [DATA_W-1:0] m_wdata,
  input  logic [OE_W-1:0]   m_oe,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [OE_W-1:0]   sys_oe
);
  always_ff @(posedge clk) begin
    if (rst || block) begin
      bus_valid <= 1'b0;
      bus_write <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      sys_oe    <= '0;
    end else begin
      bus_valid <= m_ctrl.valid;
      bus_write <= m_ctrl.write;
      bus_addr  <= m_addr;
      bus_wdata <= m_wdata;
      sys_oe    <= m_oe;
    end
  end
endmodule

// File: rtl/lockstep_monitor.sv
module lockstep_monitor
  import lsm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int OE_W   = 4,
  localparam int PAR_W = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              m_valid,
  input  logic              m_write,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic [DATA_W-1:0] m_wdata,
  input  logic [OE_W-1:0]   m_oe,
  input  logic              c_valid,
  input  logic              c_write,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [DATA_W-1:0] c_wdata,
  input  logic [OE_W-1:0]   c_oe,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [PAR_W-1:0]  rd_par,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [OE_W-1:0]   sys_oe,
  output logic              cmp_err,
  output logic              par_err,
  output logic              silent
);
  ctrl_t m_ctrl;
  ctrl_t c_ctrl;
  logic  cmp_hit;
  logic  par_hit;
  logic  block;

  assign m_ctrl = '{valid: m_valid, write: m_write};
  assign c_ctrl = '{valid: c_valid, write: c_write};

  lsm_pair_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OE_W(OE_W)) u_cmp (
    .m_ctrl(m_ctrl), .c_ctrl(c_ctrl),
    .m_addr(m_addr), .c_addr(c_addr),
    .m_wdata(m_wdata), .c_wdata(c_wdata),
    .m_oe(m_oe), .c_oe(c_oe),
    .mismatch(cmp_hit)
  );

  lsm_parity_chk #(.DATA_W(DATA_W)) u_par (
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_par(rd_par),
    .par_hit(par_hit)
  );

  lsm_fault_latch u_latch (
    .clk(clk), .rst(rst),
    .cmp_hit(cmp_hit), .par_hit(par_hit),
    .block(block),
    .cmp_err(cmp_err), .par_err(par_err), .silent(silent)
  );

  lsm_out_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OE_W(OE_W)) u_gate (
    .clk(clk), .rst(rst), .block(block),
    .m_ctrl(m_ctrl), .m_addr(m_addr), .m_wdata(m_wdata), .m_oe(m_oe),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .sys_oe(sys_oe)
  );
endmodule

// File: rtl/lsm_checker.sv
module lsm_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int OE_W   = 4,
  parameter int PAR_W  = DATA_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              m_valid,
  input logic              m_write,
  input logic [ADDR_W-1:0] m_addr,
  input logic [DATA_W-1:0] m_wdata,
  input logic [OE_W-1:0]   m_oe,
  input logic              c_valid,
  input logic              c_write,
  input logic [ADDR_W-1:0] c_addr,
  input logic [DATA_W-1:0] c_wdata,
  input logic [OE_W-1:0]   c_oe,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic [PAR_W-1:0]  rd_par,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [OE_W-1:0]   sys_oe,
  input logic              cmp_err,
  input logic              par_err,
  input logic              silent
);
  logic [PAR_W-1:0] want_par;
  logic             pair_differs;
  logic             par_bad;

  always_comb begin
    for (int i = 0; i < PAR_W; i++) want_par[i] = ^rd_data[i*8 +: 8];
  end

  assign pair_differs = !c_valid || (m_write != c_write) || (m_addr != c_addr) ||
                        (m_wdata != c_wdata) || (m_oe != c_oe);
  assign par_bad      = rd_valid && (rd_par != want_par);

  p_sticky_cmp_r2: assert property (@(posedge clk) disable iff (rst)
    cmp_err |=> cmp_err);

  p_detect_r2: assert property (@(posedge clk) disable iff (rst)
    (m_valid && pair_differs) |=> cmp_err);

  p_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !m_valid |=> $stable(cmp_err));

  p_fwd_r4: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !pair_differs && !par_bad && !cmp_err && !par_err)
    |=> (bus_valid && bus_write == $past(m_write) && bus_addr == $past(m_addr) &&
         bus_wdata == $past(m_wdata) && sys_oe == $past(m_oe)));

  p_sticky_par_r5: assert property (@(posedge clk) disable iff (rst)
    par_err |=> par_err);

  p_detect_par_r5: assert property (@(posedge clk) disable iff (rst)
    par_bad |=> par_err);

  p_silent_r6: assert property (@(posedge clk) disable iff (rst)
    (cmp_err || par_err) |-> silent);

  p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    silent |-> (!bus_valid && !bus_write && bus_addr == '0 &&
                bus_wdata == '0 && sys_oe == '0));
endmodule

bind lockstep_monitor lsm_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OE_W(OE_W), .PAR_W(PAR_W)
) chk_i (.*);

// File: tb/lockstep_monitor_tb_top.sv
module lockstep_monitor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int OE_W   = 4;
  localparam int PAR_W  = DATA_W / 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_valid = 0, m_write = 0, c_valid = 0, c_write = 0, rd_valid = 0;
  logic [ADDR_W-1:0] m_addr = '0, c_addr = '0;
  logic [DATA_W-1:0] m_wdata = '0, c_wdata = '0, rd_data = '0;
  logic [OE_W-1:0]   m_oe = '0, c_oe = '0;
  logic [PAR_W-1:0]  rd_par = '0;
  logic bus_valid, bus_write, cmp_err, par_err, silent;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic [OE_W-1:0]   sys_oe;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;
  bit e_cmp = 0, e_par = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lockstep_monitor #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OE_W(OE_W)) dut_i (.*);

  function automatic logic [PAR_W-1:0] good_par(input logic [DATA_W-1:0] d);
    logic [PAR_W-1:0] p;
    for (int i = 0; i < PAR_W; i++) p[i] = ^d[i*8 +: 8];
    return p;
  endfunction

  function automatic logic [63:0] pack_bus(input logic v, input logic w,
      input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input logic [OE_W-1:0] o);
    return 64'({v, w, a, d, o});
  endfunction

  task automatic check(input bit ok, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  // One clock: the reference model computes the outputs expected after the edge.
  task automatic step(input string tag);
    bit mm, pe, blk;
    logic [63:0] exp_bus, act_bus;
    @(posedge clk);
    #1;
    if (rst) begin
      e_cmp = 0; e_par = 0; blk = 1;
    end else begin
      mm = m_valid && ({c_valid, c_write, c_addr, c_wdata, c_oe} !=
                       {1'b1, m_write, m_addr, m_wdata, m_oe});
      pe = rd_valid && (rd_par != good_par(rd_data));
      e_cmp = e_cmp | mm;
      e_par = e_par | pe;
      blk = e_cmp | e_par;
    end
    exp_bus = blk ? 64'd0 : pack_bus(m_valid, m_write, m_addr, m_wdata, m_oe);
    act_bus = pack_bus(bus_valid, bus_write, bus_addr, bus_wdata, sys_oe);
    check(cmp_err == e_cmp, {tag, " cmp_err"}, 64'(cmp_err), 64'(e_cmp));
    check(par_err == e_par, {tag, " par_err"}, 64'(par_err), 64'(e_par));
    check(silent == (e_cmp | e_par), {tag, " R6 silent"}, 64'(silent), 64'(e_cmp | e_par));
    check(act_bus == exp_bus, {tag, " R4/R6 forwarded outputs"}, act_bus, exp_bus);
  endtask

  task automatic set_healthy(input logic v);
    m_valid = v; m_write = 1'($urandom);
    m_addr = ADDR_W'($urandom); m_wdata = $urandom; m_oe = OE_W'($urandom);
    c_valid = m_valid; c_write = m_write; c_addr = m_addr; c_wdata = m_wdata; c_oe = m_oe;
    rd_valid = 1'($urandom); rd_data = $urandom; rd_par = good_par(rd_data);
  endtask

  task automatic do_reset();
    rst = 1; set_healthy(1); step("R1");
    check(!cmp_err && !par_err && !silent && !bus_valid && sys_oe == 0 && bus_addr == 0,
          "R1 reset state", 64'({cmp_err, par_err, silent, bus_valid}), 64'd0);
    rst = 0;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<=200000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();

    // R3: idle cycle with disagreeing checker is ignored.
    set_healthy(0); c_valid = 1; c_addr = ~m_addr; c_oe = ~m_oe;
    step("R3");
    check(!cmp_err, "R3 idle mismatch ignored", 64'(cmp_err), 64'd0);
    set_healthy(1); step("R4");
    check(bus_valid && bus_addr == m_addr, "R4 healthy request forwarded",
          64'(bus_addr), 64'(m_addr));

    // R7: master-side bit flip.
    set_healthy(1); m_addr[3] = ~m_addr[3]; step("R7");
    check(cmp_err && !bus_valid, "R7 master-side flip flagged and blocked",
          64'({cmp_err, bus_valid}), 64'b10);
    set_healthy(1); step("R2");
    check(cmp_err && !bus_valid, "R2 sticky, R6 still silent",
          64'({cmp_err, bus_valid}), 64'b10);
    do_reset();

    // R7: checker-side bit flip on data.
    set_healthy(1); c_wdata[17] = ~c_wdata[17]; step("R7");
    check(cmp_err, "R7 checker-side flip flagged", 64'(cmp_err), 64'd1);
    do_reset();

    // R2: checker strobe missing is a control-line mismatch.
    set_healthy(1); c_valid = 0; step("R2");
    check(cmp_err, "R2 valid pair mismatch", 64'(cmp_err), 64'd1);
    do_reset();

    // R5: bad parity ignored when not valid, then detected.
    set_healthy(1); rd_valid = 0; rd_par[1] = ~rd_par[1]; step("R5");
    check(!par_err, "R5 parity ignored without rd_valid", 64'(par_err), 64'd0);
    set_healthy(1); rd_valid = 1; rd_par[PAR_W-1] = ~rd_par[PAR_W-1]; step("R5");
    check(par_err && !cmp_err && !bus_valid, "R5 parity fault silences",
          64'({par_err, cmp_err, bus_valid}), 64'b100);
    set_healthy(1); step("R6");
    check(!bus_valid && sys_oe == 0, "R6 outputs held after parity fault",
          64'({bus_valid, sys_oe}), 64'd0);
    do_reset();

    // R8: both faults in one cycle.
    set_healthy(1); c_addr[0] = ~c_addr[0]; rd_valid = 1; rd_par[0] = ~rd_par[0];
    step("R8");
    check(cmp_err && par_err && silent && !bus_valid, "R8 both flags same edge",
          64'({cmp_err, par_err, silent, bus_valid}), 64'b1110);
    do_reset();

    // Random episodes with rare injection on either side and on parity.
    for (int ep = 0; ep < 150; ep++) begin
      for (int cy = 0; cy < 60; cy++) begin
        set_healthy(1'(($urandom % 4) != 0));
        if (($urandom % 6) == 0) begin
          c_addr = ADDR_W'($urandom); c_valid = 1'($urandom);
        end
        if (($urandom % 40) == 0) begin
          case ($urandom % 5)
            0: m_wdata[$urandom % DATA_W] = ~m_wdata[$urandom % DATA_W];
            1: c_addr[$urandom % ADDR_W] = ~c_addr[$urandom % ADDR_W];
            2: c_write = ~c_write;
            3: m_oe[$urandom % OE_W] = ~m_oe[$urandom % OE_W];
            default: c_valid = 0;
          endcase
        end
        if (($urandom % 50) == 0) rd_par[$urandom % PAR_W] = ~rd_par[$urandom % PAR_W];
        step("R2");
      end
      do_reset();
    end

    finish_run();
  end
endmodule